// File: doc/BRIEF.md
# Power-on strap sampling sequencer

This block owns a group of dual-purpose pads that carry configuration straps right after power-up and carry clock outputs afterwards. Once the supply-good indication rises, it keeps every one of these pads in three-state for a settling window whose length is set by a parameter in reference-clock cycles. It then captures the synchronized pad levels into a latch that can be written once, and one cycle later it turns the pad drivers on.

The captured word has two parts. The low bits form the hardware frequency-select code. The top bit selects what a separate shared pad does. When that bit is 1, the shared pad is a reference-clock output. When it is 0, the shared pad is an active-low input that stops the CPU clock.

The captured word is not written again until power-on reset asserts. Pad activity, supply-good glitches and clock traffic after the capture have no effect on it.

Top module: `strap_sampler`

## Requirements
- R1: While `por_n` is low, and after it rises until the capture, `straps_valid`, `pad_oe` and `ref0_oe` are 0 and `cpu_stop_n` is 1. Before the capture, `freq_code` and `mode_bit` show the unstrapped levels: the top frequency bit is 0, the other frequency bits are 1 and `mode_bit` is 1.
- R2: The settling window starts at the first clock edge that samples `supply_good` high. If `supply_good` goes low before the window ends, the window is abandoned and starts again from zero at the next rising edge.
- R3: Every bit of `pad_oe` is 0 for as long as `straps_valid` is 0.
- R4: Take the edge that starts an uninterrupted window as edge 0. `straps_valid` rises at edge SETTLE_CYCLES+2.
- R5: Pad bit i (i < NUM_FS) is captured as `freq_code[i]`, and pad bit NUM_FS is captured as `mode_bit`. The captured values are the pad levels, provided the pads are held stable through the window.
- R6: After the capture, `freq_code`, `mode_bit` and `straps_valid` stay fixed until `por_n` asserts. Changes on `pad_in` and on `supply_good` have no effect on them.
- R7: The latch takes its value one cycle before the drivers turn on. `freq_code` is final one cycle before `straps_valid` rises, and `pad_oe` goes all ones together with `straps_valid`.
- R8: With `mode_bit` = 1 after the capture, `ref0_oe` is 1 and `cpu_stop_n` stays at 1 whatever `stop_pin_in` does.
- R9: With `mode_bit` = 0 after the capture, `ref0_oe` is 0 and `cpu_stop_n` follows `stop_pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low; asserted only when power is removed |
| supply_good | input | 1 | Digital supply-good indication, synchronous to clk |
| pad_in | input | NUM_FS+1 | Levels seen on the dual-purpose pads; bits NUM_FS-1..0 are the frequency selects, bit NUM_FS is the mode strap |
| stop_pin_in | input | 1 | Level seen on the shared pad when it acts as an input |
| pad_oe | output | NUM_FS+1 | Output-buffer enable for each dual-purpose pad |
| ref0_oe | output | 1 | Output enable of the shared pad in reference-clock mode |
| cpu_stop_n | output | 1 | CPU clock stop request, active low |
| freq_code | output | NUM_FS | Captured hardware frequency-select code |
| mode_bit | output | 1 | Captured mode strap |
| straps_valid | output | 1 | Straps captured and pad drivers enabled |

## Verification
The bench builds the block with SETTLE_CYCLES = 40 and leaves NUM_FS and SYNC_STAGES at their defaults. The short window makes it practical to cover many power cycles. It also lets the bench test the exact edge at which `straps_valid` rises, abort the window partway and restart it, and drive pad changes after the capture. The 2 ms default only lengthens the counter; it does not change the sequence, so these runs cover every phase transition.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [2:0] {
    PH_WAIT    = 3'd0,
    PH_SETTLE  = 3'd1,
    PH_CAPTURE = 3'd2,
    PH_HOLD    = 3'd3,
    PH_DRIVE   = 3'd4
  } strap_phase_e;

  // Unstrapped level of each pad: the top frequency bit has a pull-down,
  // every other pad (including mode) has a pull-up.
  function automatic logic [31:0] strap_default_word(int nfs);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < nfs - 1; i++) w[i] = 1'b1;
    w[nfs] = 1'b1;
    return w;
  endfunction

  // Cycles from the window-start edge to straps_valid rising.
  function automatic int strap_valid_latency(int settle);
    return settle + 2;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int          W      = 5,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[0] <= INIT;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= INIT;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 28636
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         supply_good,
  output logic         capture_stb,
  output logic         drive_en,
  output strap_phase_e phase_o
);
  localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  strap_phase_e phase_q;
  logic [CW-1:0] cnt_q;
  logic          window_done;

  assign window_done = (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_WAIT: begin
          cnt_q <= '0;
          if (supply_good) phase_q <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (!supply_good) begin
            phase_q <= PH_WAIT;
            cnt_q   <= '0;
          end else if (window_done) begin
            phase_q <= PH_CAPTURE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAPTURE: phase_q <= PH_HOLD;
        PH_HOLD:    phase_q <= PH_DRIVE;
        default:    phase_q <= PH_DRIVE;
      endcase
    end
  end

  assign capture_stb = (phase_q == PH_CAPTURE);
  assign drive_en    = (phase_q == PH_DRIVE);
  assign phase_o     = phase_q;

  // R2
  settle_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase_q == PH_SETTLE && !supply_good) |=> (phase_q == PH_WAIT));

  // R4
  settle_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase_q == PH_SETTLE) |-> (cnt_q <= LAST));

  // R4
  capture_after_full_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(capture_stb) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int           W    = 5,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         capture_stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         locked
);
  logic [W-1:0] q_r;
  logic         locked_r;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      q_r      <= INIT;
      locked_r <= 1'b0;
    end else if (capture_stb && !locked_r) begin
      q_r      <= d;
      locked_r <= 1'b1;
    end
  end

  assign q      = q_r;
  assign locked = locked_r;

  // R6
  frozen_after_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    locked_r |=> ($stable(q_r) && locked_r));

  // R6
  no_recapture_chk: assert property (@(posedge clk) disable iff (!por_n)
    locked_r |-> !capture_stb);

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int NUM_FS        = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 28636
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              supply_good,
  input  logic [NUM_FS:0]   pad_in,
  input  logic              stop_pin_in,
  output logic [NUM_FS:0]   pad_oe,
  output logic              ref0_oe,
  output logic              cpu_stop_n,
  output logic [NUM_FS-1:0] freq_code,
  output logic              mode_bit,
  output logic              straps_valid
);
  localparam int              STRAP_W  = NUM_FS + 1;
  localparam logic [31:0]     DEF_WORD = strap_default_word(NUM_FS);
  localparam logic [STRAP_W-1:0] DEF   = DEF_WORD[STRAP_W-1:0];

  logic [STRAP_W-1:0] pad_sync;
  logic [STRAP_W-1:0] strap_q;
  logic               capture_stb;
  logic               drive_en;
  logic               locked;
  strap_phase_e       phase;

  strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES), .INIT(DEF)) u_sync (
    .clk(clk), .por_n(por_n), .d(pad_in), .q(pad_sync)
  );

  strap_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .supply_good(supply_good),
    .capture_stb(capture_stb), .drive_en(drive_en), .phase_o(phase)
  );

  strap_latch #(.W(STRAP_W), .INIT(DEF)) u_latch (
    .clk(clk), .por_n(por_n), .capture_stb(capture_stb),
    .d(pad_sync), .q(strap_q), .locked(locked)
  );

  assign straps_valid = drive_en;
  assign pad_oe       = {STRAP_W{drive_en}};
  assign freq_code    = strap_q[NUM_FS-1:0];
  assign mode_bit     = strap_q[NUM_FS];
  assign ref0_oe      = drive_en & strap_q[NUM_FS];
  assign cpu_stop_n   = (drive_en && !strap_q[NUM_FS]) ? stop_pin_in : 1'b1;

  // R7
  drive_follows_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(straps_valid) |-> $past(capture_stb, 2));

  // R7
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    straps_valid |-> locked);

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    straps_valid |=> straps_valid);

  // R3
  pads_quiet_in_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase != PH_DRIVE) |-> (pad_oe == '0));

endmodule

// File: tb/strap_sampler_tb.sv
`timescale 1ns/1ps
module strap_sampler_tb;
  localparam int NFS = 4;
  localparam int S   = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_good = 1'b0;
  logic [NFS:0] pad_in = '0;
  logic stop_pin_in = 1'b1;
  logic [NFS:0] pad_oe;
  logic ref0_oe, cpu_stop_n, mode_bit, straps_valid;
  logic [NFS-1:0] freq_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strap_sampler #(.NUM_FS(NFS), .SYNC_STAGES(2), .SETTLE_CYCLES(S)) u_dut (
    .clk(clk), .por_n(por_n), .supply_good(supply_good), .pad_in(pad_in),
    .stop_pin_in(stop_pin_in), .pad_oe(pad_oe), .ref0_oe(ref0_oe),
    .cpu_stop_n(cpu_stop_n), .freq_code(freq_code), .mode_bit(mode_bit),
    .straps_valid(straps_valid)
  );

  function automatic logic [NFS:0] exp_default();
    logic [NFS:0] v;
    v = '1;
    v[NFS-1] = 1'b0;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_idle_outputs(string req);
    chk(req, {31'd0, straps_valid}, 0);
    chk(req, 32'(pad_oe), 0);
    chk(req, {31'd0, ref0_oe}, 0);
    chk(req, {31'd0, cpu_stop_n}, 1);
  endtask

  // Counts negedges after supply_good rises until straps_valid is seen.
  task automatic run_window(logic [NFS:0] pat, bit abort);
    int n;
    logic [NFS-1:0] code_before;
    supply_good = 1'b1;
    if (abort) begin
      for (int k = 0; k < S / 2; k++) @(negedge clk);
      supply_good = 1'b0;
      @(negedge clk); @(negedge clk);
      // R2 aborted window must not complete
      check_idle_outputs("R2");
      supply_good = 1'b1;
    end
    n = 0;
    code_before = '0;
    while (!straps_valid && n < S + 60) begin
      @(negedge clk);
      n++;
      if (!straps_valid) begin
        if (pad_oe != 0) begin
          chk("R3", 32'(pad_oe), 0);
        end
        code_before = freq_code;
      end
    end
    // R4 valid at edge S+2 after start, seen on negedge S+3
    chk("R4", 32'(n), 32'(S + 3));
    // R7 code final one cycle before valid
    chk("R7", 32'(code_before), 32'(pat[NFS-1:0]));
    chk("R7", 32'(pad_oe), 32'({(NFS+1){1'b1}}));
    // R5
    chk("R5", 32'(freq_code), 32'(pat[NFS-1:0]));
    chk("R5", {31'd0, mode_bit}, {31'd0, pat[NFS]});
  endtask

  task automatic trial(logic [NFS:0] pat, bit abort);
    logic [NFS:0] junk;
    por_n = 1'b0;
    supply_good = 1'b0;
    pad_in = $urandom();
    repeat (3) @(negedge clk);
    // R1
    check_idle_outputs("R1");
    chk("R1", 32'({mode_bit, freq_code}), 32'(exp_default()));
    por_n = 1'b1;
    pad_in = pat;
    repeat ($urandom_range(1, 6)) @(negedge clk);
    check_idle_outputs("R1");
    chk("R1", 32'({mode_bit, freq_code}), 32'(exp_default()));
    run_window(pat, abort);
    // R8 / R9
    stop_pin_in = 1'b0;
    #0.1;
    if (pat[NFS]) begin
      chk("R8", {31'd0, ref0_oe}, 1);
      chk("R8", {31'd0, cpu_stop_n}, 1);
    end else begin
      chk("R9", {31'd0, ref0_oe}, 0);
      chk("R9", {31'd0, cpu_stop_n}, 0);
      stop_pin_in = 1'b1;
      #0.1;
      chk("R9", {31'd0, cpu_stop_n}, 1);
    end
    stop_pin_in = 1'b1;
    // R6 disturb pads and supply_good after capture
    junk = ~pat;
    pad_in = junk;
    supply_good = 1'b0;
    repeat (6) @(negedge clk);
    supply_good = 1'b1;
    repeat (S + 6) @(negedge clk);
    chk("R6", 32'({mode_bit, freq_code}), 32'(pat));
    chk("R6", {31'd0, straps_valid}, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0412));
    trial(exp_default(), 1'b0);
    trial('0, 1'b0);
    trial('1, 1'b1);
    trial(5'b01010, 1'b1);
    for (int t = 0; t < 10; t++) trial(5'($urandom()), 1'($urandom()));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule